// File: doc/BRIEF.md
# Nibble-Bus RAM Bank Selector

This block produces the memory command strobes for a processor that moves 4-bit values over a multiplexed bus. Each bus cycle has eight phases, and a sync pulse marks the first of them. A bank code is captured from the low bits of the accumulator whenever the instruction decoder flags a bank-designate instruction. That code persists across any number of later instructions. During every RAM or I/O instruction, the block raises the RAM command lines that match the stored code. It raises them only in the execute phase where memory devices sample their line. It also produces a single ROM command strobe, which marks the fetch phase and the memory-operation phase.

There are four RAM command lines. Code 0 selects line 0 alone, and codes 1 to 7 drive lines 1 to 3 with the code's binary value. An optional set of eight fully decoded bank strobes shows the one-hot form that a single external decoder would build from those lines, so systems with more banks can use it directly. The phase tracker ignores the bus until it has seen a sync pulse after reset. After that it free-runs through the eight phases and lines up again on each new pulse.

Top module: `nibble_bank_sel`

## Requirements
- R1: While reset is low, every command output is 0. After reset the stored bank code is 0, so the first memory operation drives ram_cmd = 4'b0001.
- R2: A cycle with sync high is phase A1, and the cycles that follow are A2, A3, M1, M2, X1, X2, X3, then A1 again if no new sync arrives. Before the first sync after reset, every command output stays 0.
- R3: A cycle with dcl_stb high stores acc[2:0] as the bank code at the clock edge that ends it. The code then holds until the next such cycle, and acc has no effect in any other cycle.
- R4: When RAM lines are driven, code 0 gives ram_cmd = 4'b0001 and code c (1 to 7) gives ram_cmd = {c, 1'b0}.
- R5: ram_cmd is nonzero only in phase X2 (the seventh phase, counting the sync cycle as the first) of a cycle in which mem_op is high. In all other cases it is 4'b0000.
- R6: In the same window as R5, bank_dec has exactly bit c set for bank code c. Outside that window it is 0.
- R7: rom_cmd is high in phase A3 (the third phase) of every bus cycle, which marks the instruction fetch.
- R8: rom_cmd is high in phase M2 (the fifth phase) only when mem_op is high. It is low in all remaining phases.
- R9: acc[3] never affects the stored bank code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync | input | 1 | High in the A1 cycle of a bus cycle |
| dcl_stb | input | 1 | Decoder strobe: bank-designate instruction executes |
| mem_op | input | 1 | Current instruction is a RAM or I/O operation |
| acc | input | 4 | Accumulator value |
| ram_cmd | output | 4 | RAM bank command lines, active high |
| bank_dec | output | 8 | One-hot decoded bank strobe for eight-bank systems |
| rom_cmd | output | 1 | ROM command line, active high |

## Verification
The table of bus cycles steps the bank code through all eight values. This separates the special single-line mapping of code 0 from the binary mapping of codes 1 to 7, and it confirms that the decoded strobe follows the same code. Some rows repeat a cycle without a designate strobe while a different value sits on the accumulator. These rows show that the code holds, and a value with bit 3 set shows that the top accumulator bit is dropped. Rows with mem_op low tell the fetch-only ROM strobe apart from the memory-operation strobe and confirm that the RAM lines stay quiet. Directed runs cover outputs before the first sync, free-running wrap without a sync, and the code returning to 0 after a reset in mid-operation.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;
  typedef enum logic [2:0] {
    PH_A1 = 3'd0,
    PH_A2 = 3'd1,
    PH_A3 = 3'd2,
    PH_M1 = 3'd3,
    PH_M2 = 3'd4,
    PH_X1 = 3'd5,
    PH_X2 = 3'd6,
    PH_X3 = 3'd7
  } phase_e;
endpackage

// File: rtl/bsel_rst_sync.sv
module bsel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/bsel_phase_seq.sv
module bsel_phase_seq
  import bank_sel_pkg::*;
(
  input  logic   clk,
  input  logic   rst_ni,
  input  logic   sync,
  output phase_e phase_o,
  output logic   locked_o
);
  phase_e phase_q, phase_d;
  logic   locked_q, locked_d;

  always_comb begin
    phase_d  = phase_q;
    locked_d = locked_q;
    if (sync) begin
      phase_d  = PH_A2;
      locked_d = 1'b1;
    end else if (locked_q) begin
      phase_d = phase_e'(phase_q + 3'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_A1;
      locked_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      locked_q <= locked_d;
    end
  end

  assign phase_o  = sync ? PH_A1 : phase_q;
  assign locked_o = locked_q;

  AST_SYNC_TO_A2: assert property (@(posedge clk) disable iff (!rst_ni)
    sync |=> (phase_q == PH_A2 && locked_q)); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (locked_q && !sync) |=> (phase_q == phase_e'($past(phase_q) + 3'd1))); // R2
endmodule

// File: rtl/bsel_bank_reg.sv
module bsel_bank_reg #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (load) code_d = code_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !load |=> $stable(code_q)); // R3
endmodule

// File: rtl/bsel_cmd_gen.sv
module bsel_cmd_gen
  import bank_sel_pkg::*;
#(
  parameter int unsigned CODE_W     = 3,
  parameter bit          EXT_DECODE = 1'b1,
  localparam int unsigned LINES     = CODE_W + 1,
  localparam int unsigned BANKS     = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  phase_e            phase,
  input  logic              locked,
  input  logic              mem_op,
  input  logic [CODE_W-1:0] code,
  output logic [LINES-1:0]  ram_cmd,
  output logic [BANKS-1:0]  bank_dec,
  output logic              rom_cmd
);
  logic             ram_win;
  logic [LINES-1:0] line_pat;

  assign ram_win = locked && mem_op && (phase == PH_X2);

  always_comb begin
    if (code == '0) line_pat = LINES'(1);
    else            line_pat = {code, 1'b0};
  end

  assign ram_cmd = ram_win ? line_pat : '0;
  assign rom_cmd = locked && ((phase == PH_A3) || (mem_op && phase == PH_M2));

  generate
    if (EXT_DECODE) begin : g_dec
      always_comb begin
        bank_dec = '0;
        if (ram_win) bank_dec[code] = 1'b1;
      end
    end else begin : g_nodec
      assign bank_dec = '0;
    end
  endgenerate

  AST_RAM_X2_ONLY: assert property (@(posedge clk) disable iff (!rst_ni)
    (ram_cmd != '0) |-> (phase == PH_X2 && mem_op && locked)); // R5
  AST_RAM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_X2 && mem_op && locked) |-> (ram_cmd != '0)); // R4
  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(bank_dec)); // R6
  AST_ROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_ni)
    rom_cmd |-> (phase == PH_A3 || (phase == PH_M2 && mem_op))); // R8
endmodule

// File: rtl/nibble_bank_sel.sv
module nibble_bank_sel
  import bank_sel_pkg::*;
#(
  parameter int unsigned ACC_W      = 4,
  parameter int unsigned CODE_W     = 3,
  parameter bit          EXT_DECODE = 1'b1,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned LINES     = CODE_W + 1,
  localparam int unsigned BANKS     = 1 << CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             dcl_stb,
  input  logic             mem_op,
  input  logic [ACC_W-1:0] acc,
  output logic [LINES-1:0] ram_cmd,
  output logic [BANKS-1:0] bank_dec,
  output logic             rom_cmd
);
  logic              rst_ni;
  phase_e            phase;
  logic              locked;
  logic [CODE_W-1:0] code;
  logic              unused_acc_hi;

  assign unused_acc_hi = ^acc[ACC_W-1:CODE_W]; // R9: upper accumulator bits dropped

  bsel_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_ni)
  );

  bsel_phase_seq u_phase (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .sync     (sync),
    .phase_o  (phase),
    .locked_o (locked)
  );

  bsel_bank_reg #(.CODE_W(CODE_W)) u_bank (
    .clk    (clk),
    .rst_ni (rst_ni),
    .load   (dcl_stb),
    .code_i (acc[CODE_W-1:0]),
    .code_o (code)
  );

  bsel_cmd_gen #(.CODE_W(CODE_W), .EXT_DECODE(EXT_DECODE)) u_cmd (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .phase    (phase),
    .locked   (locked),
    .mem_op   (mem_op),
    .code     (code),
    .ram_cmd  (ram_cmd),
    .bank_dec (bank_dec),
    .rom_cmd  (rom_cmd)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (ram_cmd == '0 && bank_dec == '0 && !rom_cmd)); // R1
endmodule

// File: tb/nibble_bank_sel_test.sv
module nibble_bank_sel_test;
  logic       clk = 1'b0;
  logic       rst_n, sync, dcl_stb, mem_op;
  logic [3:0] acc;
  logic [3:0] ram_cmd;
  logic [7:0] bank_dec;
  logic       rom_cmd;
  int         total = 0;
  int         bad   = 0;

  always #2.5 clk = ~clk;

  nibble_bank_sel uut (
    .clk(clk), .rst_n(rst_n), .sync(sync), .dcl_stb(dcl_stb), .mem_op(mem_op),
    .acc(acc), .ram_cmd(ram_cmd), .bank_dec(bank_dec), .rom_cmd(rom_cmd)
  );

  // fields: [17] designate, [16:13] acc, [12] mem_op, [11:8] ram lines, [7:0] decoded
  localparam logic [17:0] VEC [12] = '{
    {1'b0, 4'hF, 1'b1, 4'b0001, 8'h01},  // R1 reset code 0, acc ignored
    {1'b1, 4'h1, 1'b1, 4'b0010, 8'h02},  // R4
    {1'b1, 4'h2, 1'b1, 4'b0100, 8'h04},
    {1'b1, 4'h3, 1'b1, 4'b0110, 8'h08},
    {1'b1, 4'h4, 1'b1, 4'b1000, 8'h10},
    {1'b1, 4'h5, 1'b0, 4'b0000, 8'h00},  // R5 no memory op
    {1'b0, 4'h0, 1'b1, 4'b1010, 8'h20},  // R3 code 5 held
    {1'b1, 4'h6, 1'b1, 4'b1100, 8'h40},
    {1'b1, 4'h7, 1'b1, 4'b1110, 8'h80},
    {1'b1, 4'h8, 1'b1, 4'b0001, 8'h01},  // R9 bit 3 dropped
    {1'b1, 4'hB, 1'b0, 4'b0000, 8'h00},  // R8 fetch only
    {1'b0, 4'h7, 1'b1, 4'b0110, 8'h08}   // R3 code 3 held
  };

  task automatic check(input string tag, input logic [12:0] got, input logic [12:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: {ram,dec,rom} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic bus_run(input int nph, input logic dcl, input logic [3:0] a,
                         input logic mop, input logic [3:0] eram, input logic [7:0] edec,
                         input string tag);
    for (int i = 0; i < nph; i++) begin
      int ph;
      logic [3:0] xr;
      logic [7:0] xd;
      logic xrom;
      ph = i % 8;
      @(posedge clk); #1;
      sync    = (i == 0);
      dcl_stb = dcl && (i == 0);
      acc     = a;
      mem_op  = mop;
      @(negedge clk);
      xr   = (ph == 6 && mop) ? eram : 4'b0000;
      xd   = (ph == 6 && mop) ? edec : 8'h00;
      xrom = (ph == 2) || (ph == 4 && mop);
      case (ph)
        2:       check({tag, " R7"}, {ram_cmd, bank_dec, rom_cmd}, {xr, xd, xrom});
        4:       check({tag, " R8"}, {ram_cmd, bank_dec, rom_cmd}, {xr, xd, xrom});
        6:       check({tag, " R4/R6"}, {ram_cmd, bank_dec, rom_cmd}, {xr, xd, xrom});
        default: check({tag, " R5"}, {ram_cmd, bank_dec, rom_cmd}, {xr, xd, xrom});
      endcase
    end
    @(posedge clk); #1;
    sync = 1'b0; dcl_stb = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync = 1'b0; dcl_stb = 1'b0; mem_op = 1'b1; acc = 4'h0;
    @(negedge clk);
    check("R1 in reset", {ram_cmd, bank_dec, rom_cmd}, 13'b0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R2: no sync yet, nothing may be driven
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check("R2 unlocked", {ram_cmd, bank_dec, rom_cmd}, 13'b0);
    end
    for (int k = 0; k < 12; k++)
      bus_run(8, VEC[k][17], VEC[k][16:13], VEC[k][12], VEC[k][11:8], VEC[k][7:0],
              $sformatf("row%0d", k));
    // R2: free-running through two cycles after one sync (code 3 stored)
    bus_run(16, 1'b0, 4'h0, 1'b1, 4'b0110, 8'h08, "R2 wrap");
    // R1: reset in mid-operation clears the code
    @(posedge clk); #1;
    rst_n = 1'b0; mem_op = 1'b1;
    @(negedge clk);
    check("R1 mid reset", {ram_cmd, bank_dec, rom_cmd}, 13'b0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    bus_run(8, 1'b0, 4'h6, 1'b1, 4'b0001, 8'h01, "R1 after reset");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule